// File: doc/BRIEF.md
# Linked-List Hardware Queue Manager

This block keeps many descriptor queues in hardware. Each queue is a singly linked list threaded through one shared link store. The store is addressed by descriptor index, so every descriptor owns exactly one link entry. For each queue the block keeps a head pointer, a tail pointer, an entry count and a pending flag. Software or a DMA engine issues one command per cycle: push an index to the tail, push an index to the head, or pop from the head. A pop always returns the head entry.

Each link entry carries sideband data next to the next-pointer. This is a 4-bit hint taken from the push command and a packet-size value. The size comes from a side register that a separate write loads and the next push consumes. The block works on indexes only. It never touches descriptor memory and never computes a size. Per-queue pending flags tell consumers that work is waiting. A parameterised window of queues also produces one-cycle start pulses for external channels when a push lands in an empty queue.

Top module: `qm_list_manager`

## Requirements
- R1: After reset every queue count reads 0, every pending flag and every channel start pulse is low, `pop_valid` is low, and a pop of any queue returns the null result.
- R2: Indexes pushed with the tail opcode (`cmd_op` = 2'b01) are returned by later pops of that queue in push order.
- R3: An index pushed with the head opcode (`cmd_op` = 2'b10) becomes the head, so it is the next index popped from that queue.
- R4: A pop command (`cmd_op` = 2'b11) raises `pop_valid` for exactly the one cycle after the command edge. In that cycle `pop_index`, `pop_hint` and `pop_size` carry the head entry. `pop_valid` stays low after any other command or idle cycle.
- R5: A pop of an empty queue returns `pop_empty` = 1 with index, hint and size all 0, and leaves every count and flag unchanged.
- R6: A push stores `cmd_hint` and the size side register with the index. A write (`size_wr`) in the same cycle as a push is used by that push. A push clears the side register to 0, so a push without a fresh write stores size 0.
- R7: A queue's count rises by 1 on each push and falls by 1 on each pop of a non-empty queue. The new value is visible on `q_count` one cycle after the command edge. Queue q occupies bits [q*CNT_W +: CNT_W], with CNT_W = clog2(DEPTH+1). The count saturates at DEPTH.
- R8: A queue's pending flag rises one cycle after a push into the empty queue. It falls one cycle after the pop that empties the queue, and is otherwise steady.
- R9: `chan_start[t]` pulses high for one cycle after a push into queue TRIG_BASE+t while that queue is empty. There is no pulse for a push into a non-empty queue.
- R10: A command on one queue leaves the counts, pending flags and list contents of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_wr | input | 1 | Load the packet-size side register |
| size_data | input | SIZE_W | Packet size to load |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 none, 01 push tail, 10 push head, 11 pop |
| cmd_queue | input | clog2(NUM_QUEUES) | Target queue number |
| cmd_index | input | clog2(DEPTH) | Descriptor index to push |
| cmd_hint | input | 4 | Hint stored with a pushed index |
| pop_valid | output | 1 | Pop result present |
| pop_empty | output | 1 | Pop found the queue empty (null result) |
| pop_index | output | clog2(DEPTH) | Popped descriptor index |
| pop_hint | output | 4 | Hint of the popped entry |
| pop_size | output | SIZE_W | Packet size of the popped entry |
| q_pending | output | NUM_QUEUES | Per-queue pending flags |
| q_count | output | NUM_QUEUES*CNT_W | Packed per-queue entry counts |
| chan_start | output | NUM_TRIG | Channel start pulses for the trigger window |

## Verification
A broken next-pointer or a stale head shows at the pop port. It surfaces on the first pop that walks past the damaged link, as an index that the push history does not predict. A count or pending flag that drifts from the true list length is visible on `q_count` and `q_pending` in the cycle after the offending command. A wrong empty decision also shows at once, either as a spurious or missing channel start pulse or as a null pop where an entry was expected. Sideband corruption stays hidden until the entry that carries it is popped, so every pushed index is eventually drained and compared.

// File: rtl/qm_pkg.sv
package qm_pkg;
  typedef enum logic [1:0] {
    QM_NOP       = 2'b00,
    QM_PUSH_TAIL = 2'b01,
    QM_PUSH_HEAD = 2'b10,
    QM_POP       = 2'b11
  } qm_op_e;

  localparam int QM_HINT_W = 4;
endpackage

// File: rtl/qm_side_ram.sv
// Sideband store (hint and packet size) per descriptor index.
// Synchronous write, synchronous read: maps onto block RAM.
module qm_side_ram #(
  parameter int DEPTH  = 32,
  parameter int AW     = 5,
  parameter int DW     = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/qm_next_table.sv
// Next-pointer store, one entry per descriptor index.
// Asynchronous read so a pop can advance the head in one cycle.
module qm_next_table #(
  parameter int DEPTH = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [AW-1:0] rdata
);
  logic [AW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qm_queue_slot.sv
// Per-queue state: head, tail, count and pending flag.
module qm_queue_slot #(
  parameter int DEPTH = 32,
  parameter int IDX_W = 5,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_tail,
  input  logic             push_head,
  input  logic             pop,
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] head_next,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             pending
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             empty;
  logic             any_push;
  logic [CNT_W-1:0] cnt_inc;

  assign empty    = (count == '0);
  assign any_push = push_tail | push_head;
  assign cnt_inc  = (count == CNT_MAX) ? count : count + CNT_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      pending <= 1'b0;
    end else begin
      if (push_tail) begin
        tail <= idx;
        if (empty) head <= idx;
      end
      if (push_head) begin
        head <= idx;
        if (empty) tail <= idx;
      end
      if (any_push) begin
        count <= cnt_inc;
        if (empty) pending <= 1'b1;
      end
      if (pop && !empty) begin
        head  <= head_next;
        count <= count - CNT_ONE;
        if (count == CNT_ONE) pending <= 1'b0;
      end
    end
  end

  // R8: the pending flag follows list occupancy
  p_pend_tracks_count_r8: assert property (@(posedge clk) disable iff (rst)
    pending == (count != '0));

  // R7: the count never passes the link store depth
  p_count_bound_r7: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_MAX);

  // R2: a tail push makes the pushed index the tail
  p_tail_push_r2: assert property (@(posedge clk) disable iff (rst)
    push_tail |=> tail == $past(idx));

  // R3: a head push makes the pushed index the head
  p_head_push_r3: assert property (@(posedge clk) disable iff (rst)
    push_head |=> head == $past(idx));

  // R8: a push into an empty queue raises pending
  p_pend_rise_r8: assert property (@(posedge clk) disable iff (rst)
    (any_push && empty) |=> pending);
endmodule

// File: rtl/qm_list_manager.sv
module qm_list_manager #(
  parameter int NUM_QUEUES = 8,
  parameter int DEPTH      = 32,
  parameter int SIZE_W     = 8,
  parameter int TRIG_BASE  = 4,
  parameter int NUM_TRIG   = 2,
  localparam int QW        = $clog2(NUM_QUEUES),
  localparam int IDX_W     = $clog2(DEPTH),
  localparam int CNT_W     = $clog2(DEPTH + 1),
  localparam int HINT_W    = qm_pkg::QM_HINT_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        size_wr,
  input  logic [SIZE_W-1:0]           size_data,
  input  logic                        cmd_valid,
  input  logic [1:0]                  cmd_op,
  input  logic [QW-1:0]               cmd_queue,
  input  logic [IDX_W-1:0]            cmd_index,
  input  logic [HINT_W-1:0]           cmd_hint,
  output logic                        pop_valid,
  output logic                        pop_empty,
  output logic [IDX_W-1:0]            pop_index,
  output logic [HINT_W-1:0]           pop_hint,
  output logic [SIZE_W-1:0]           pop_size,
  output logic [NUM_QUEUES-1:0]       q_pending,
  output logic [NUM_QUEUES*CNT_W-1:0] q_count,
  output logic [NUM_TRIG-1:0]         chan_start
);
  import qm_pkg::*;

  localparam int SIDE_W = HINT_W + SIZE_W;

  qm_op_e op;
  logic   is_ptail, is_phead, is_push, is_pop;

  assign op       = qm_op_e'(cmd_op);
  assign is_ptail = cmd_valid && (op == QM_PUSH_TAIL);
  assign is_phead = cmd_valid && (op == QM_PUSH_HEAD);
  assign is_pop   = cmd_valid && (op == QM_POP);
  assign is_push  = is_ptail | is_phead;

  // Per-queue state
  logic [IDX_W-1:0] head_a [NUM_QUEUES];
  logic [IDX_W-1:0] tail_a [NUM_QUEUES];
  logic [CNT_W-1:0] cnt_a  [NUM_QUEUES];
  logic [IDX_W-1:0] head_next;

  genvar gq;
  generate
    for (gq = 0; gq < NUM_QUEUES; gq++) begin : g_slot
      localparam logic [QW-1:0] QID = QW'(gq);
      logic hit;
      assign hit = (cmd_queue == QID);

      qm_queue_slot #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
      ) u_slot (
        .clk       (clk),
        .rst       (rst),
        .push_tail (is_ptail && hit),
        .push_head (is_phead && hit),
        .pop       (is_pop && hit),
        .idx       (cmd_index),
        .head_next (head_next),
        .head      (head_a[gq]),
        .tail      (tail_a[gq]),
        .count     (cnt_a[gq]),
        .pending   (q_pending[gq])
      );

      assign q_count[gq*CNT_W +: CNT_W] = cnt_a[gq];
    end
  endgenerate

  // Selected queue view
  logic [IDX_W-1:0] sel_head, sel_tail;
  logic             sel_empty;

  assign sel_head  = head_a[cmd_queue];
  assign sel_tail  = tail_a[cmd_queue];
  assign sel_empty = (cnt_a[cmd_queue] == '0);

  // Packet-size side register, consumed by a push
  logic [SIZE_W-1:0] size_reg, size_eff;

  assign size_eff = size_wr ? size_data : size_reg;

  always_ff @(posedge clk) begin
    if (rst)          size_reg <= '0;
    else if (is_push) size_reg <= '0;
    else if (size_wr) size_reg <= size_data;
  end

  // Link threading: tail push links old tail to new index,
  // head push links new index to old head.
  logic             nx_we;
  logic [IDX_W-1:0] nx_waddr, nx_wdata;

  assign nx_we    = is_push && !sel_empty;
  assign nx_waddr = is_ptail ? sel_tail : cmd_index;
  assign nx_wdata = is_ptail ? cmd_index : sel_head;

  qm_next_table #(
    .DEPTH (DEPTH),
    .AW    (IDX_W)
  ) u_next (
    .clk   (clk),
    .we    (nx_we),
    .waddr (nx_waddr),
    .wdata (nx_wdata),
    .raddr (sel_head),
    .rdata (head_next)
  );

  logic [SIDE_W-1:0] side_q;

  qm_side_ram #(
    .DEPTH (DEPTH),
    .AW    (IDX_W),
    .DW    (SIDE_W)
  ) u_side (
    .clk   (clk),
    .we    (is_push),
    .waddr (cmd_index),
    .wdata ({cmd_hint, size_eff}),
    .raddr (sel_head),
    .rdata (side_q)
  );

  // Pop result
  always_ff @(posedge clk) begin
    if (rst) begin
      pop_valid <= 1'b0;
      pop_empty <= 1'b0;
      pop_index <= '0;
    end else begin
      pop_valid <= is_pop;
      pop_empty <= is_pop && sel_empty;
      pop_index <= (is_pop && !sel_empty) ? sel_head : '0;
    end
  end

  logic pop_hit;
  assign pop_hit  = pop_valid && !pop_empty;
  assign pop_hint = pop_hit ? side_q[SIDE_W-1 -: HINT_W] : '0;
  assign pop_size = pop_hit ? side_q[SIZE_W-1:0] : '0;

  // Channel start pulses for the trigger window
  genvar gt;
  generate
    for (gt = 0; gt < NUM_TRIG; gt++) begin : g_trig
      localparam logic [QW-1:0] TQ = QW'(TRIG_BASE + gt);
      always_ff @(posedge clk) begin
        if (rst) chan_start[gt] <= 1'b0;
        else     chan_start[gt] <= is_push && sel_empty && (cmd_queue == TQ);
      end
    end
  endgenerate

  // R5: popping an empty queue yields the null result
  p_pop_null_r5: assert property (@(posedge clk) disable iff (rst)
    (is_pop && sel_empty) |=> (pop_valid && pop_empty && pop_index == '0));

  // R4: no pop result without a pop command
  p_pop_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !is_pop |=> !pop_valid);

  // R9: at most one channel starts per cycle
  p_chan_onehot_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chan_start));

  // R9: a push into a non-empty queue starts no channel
  p_chan_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (is_push && !sel_empty) |=> (chan_start == '0));
endmodule

// File: tb/qm_list_manager_bench.sv
`timescale 1ns/1ps
module qm_list_manager_bench;
  localparam int NQ = 4;
  localparam int DEPTH = 16;
  localparam int SIZE_W = 8;
  localparam int TRIG_BASE = 2;
  localparam int NUM_TRIG = 2;
  localparam int CNT_W = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic size_wr = 1'b0;
  logic [SIZE_W-1:0] size_data = '0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [1:0] cmd_queue = '0;
  logic [3:0] cmd_index = '0;
  logic [3:0] cmd_hint = '0;
  logic pop_valid, pop_empty;
  logic [3:0] pop_index, pop_hint;
  logic [SIZE_W-1:0] pop_size;
  logic [NQ-1:0] q_pending;
  logic [NQ*CNT_W-1:0] q_count;
  logic [NUM_TRIG-1:0] chan_start;

  always #2 clk = ~clk;

  qm_list_manager #(
    .NUM_QUEUES (NQ), .DEPTH (DEPTH), .SIZE_W (SIZE_W),
    .TRIG_BASE (TRIG_BASE), .NUM_TRIG (NUM_TRIG)
  ) u_qm_list_manager (
    .clk (clk), .rst (rst), .size_wr (size_wr), .size_data (size_data),
    .cmd_valid (cmd_valid), .cmd_op (cmd_op), .cmd_queue (cmd_queue),
    .cmd_index (cmd_index), .cmd_hint (cmd_hint),
    .pop_valid (pop_valid), .pop_empty (pop_empty), .pop_index (pop_index),
    .pop_hint (pop_hint), .pop_size (pop_size), .q_pending (q_pending),
    .q_count (q_count), .chan_start (chan_start)
  );

  int total = 0;
  int fails = 0;
  int mq [NQ][$];
  int mhint [DEPTH];
  int msize [DEPTH];
  bit used [DEPTH];
  int size_model = 0;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int cnt_of(int q);
    return int'(q_count[q*CNT_W +: CNT_W]);
  endfunction

  task automatic check_state(int exp_chan);
    for (int q = 0; q < NQ; q++) begin
      int e = mq[q].size();
      chk($sformatf("R7 R10 count q%0d", q), cnt_of(q), e);
      chk($sformatf("R8 pending q%0d", q), int'(q_pending[q]), int'(e != 0));
    end
    chk("R9 chan_start", int'(chan_start), exp_chan);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int q = 0; q < NQ; q++) mq[q].delete();
    for (int i = 0; i < DEPTH; i++) used[i] = 1'b0;
    size_model = 0;
  endtask

  task automatic write_size(int sz);
    size_wr = 1'b1;
    size_data = SIZE_W'(sz);
    @(negedge clk);
    size_wr = 1'b0;
    size_model = sz;
    chk("R4 no pop_valid on size write", int'(pop_valid), 0);
  endtask

  // code: 1 tail, 2 head, 3 pop
  task automatic do_op(int code, int q, int idx, int hint, bit wsz, int sz);
    int exp_chan = 0;
    int e_idx = 0, e_hint = 0, e_size = 0, e_empty = 0;
    bit was_empty = (mq[q].size() == 0);
    cmd_valid = 1'b1;
    cmd_op = 2'(code);
    cmd_queue = 2'(q);
    cmd_index = 4'(idx);
    cmd_hint = 4'(hint);
    size_wr = wsz;
    size_data = SIZE_W'(sz);
    if (code == 3) begin
      if (was_empty) e_empty = 1;
      else begin
        e_idx = mq[q].pop_front();
        e_hint = mhint[e_idx];
        e_size = msize[e_idx];
        used[e_idx] = 1'b0;
      end
    end else begin
      if (wsz) size_model = sz;
      mhint[idx] = hint;
      msize[idx] = size_model;
      size_model = 0;
      if (mq[q].size() < DEPTH) begin
        if (code == 1) mq[q].push_back(idx);
        else mq[q].push_front(idx);
        used[idx] = 1'b1;
      end
      if (was_empty && q >= TRIG_BASE && q < TRIG_BASE + NUM_TRIG)
        exp_chan = 1 << (q - TRIG_BASE);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    size_wr = 1'b0;
    chk("R4 pop_valid", int'(pop_valid), int'(code == 3));
    if (code == 3) begin
      chk("R5 pop_empty", int'(pop_empty), e_empty);
      chk("R2 R3 R4 pop_index", int'(pop_index), e_idx);
      chk("R6 pop_hint", int'(pop_hint), e_hint);
      chk("R6 pop_size", int'(pop_size), e_size);
    end
    check_state(exp_chan);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL R1 watchdog actual=expired expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    do_reset();
    // R1: reset state
    chk("R1 pop_valid after reset", int'(pop_valid), 0);
    check_state(0);
    for (int q = 0; q < NQ; q++) do_op(3, q, 0, 0, 1'b0, 0); // R1 R5 null pops

    // R2 R3 R6: sweep every index over every queue, mixed ends
    for (int q = 0; q < NQ; q++)
      for (int k = 0; k < 4; k++) begin
        int idx = q * 4 + k;
        if (k != 1) write_size(idx * 5 + q + 1);
        do_op((k % 2 == 0) ? 1 : 2, q, idx, (idx + q) & 15, 1'b0, 0);
      end
    for (int q = NQ - 1; q >= 0; q--)
      for (int k = 0; k < 5; k++) do_op(3, q, 0, 0, 1'b0, 0);

    // R6: same-cycle size write with push
    do_op(1, 2, 9, 7, 1'b1, 200);
    do_op(2, 2, 4, 3, 1'b0, 0);
    do_op(3, 2, 0, 0, 1'b0, 0);
    do_op(3, 2, 0, 0, 1'b0, 0);

    // R2 R3 R7 R8 R9 R10: pseudo-random interleaving
    lf = 16'hACE1;
    for (int n = 0; n < 600; n++) begin
      int q, fi;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      q = int'(lf[1:0]);
      fi = -1;
      for (int j = 0; j < DEPTH; j++) begin
        int c = (int'(lf[11:8]) + j) % DEPTH;
        if (fi < 0 && !used[c]) fi = c;
      end
      if (lf[4:2] < 3 || fi < 0) do_op(3, q, 0, 0, 1'b0, 0);
      else do_op(lf[5] ? 1 : 2, q, fi, int'(lf[15:12]), lf[6], int'(lf[14:7]));
    end
    for (int q = 0; q < NQ; q++)
      while (mq[q].size() != 0) do_op(3, q, 0, 0, 1'b0, 0);
    do_op(3, 0, 0, 0, 1'b0, 0);

    // R7: saturation at DEPTH
    do_reset();
    for (int i = 0; i < DEPTH; i++) do_op(1, 1, i, i, 1'b0, 0);
    chk("R7 full count", cnt_of(1), DEPTH);
    do_op(1, 1, 3, 0, 1'b0, 0);
    chk("R7 saturated count", cnt_of(1), DEPTH);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule